// File: doc/BRIEF.md
# Standby Mode Sequencer

This block puts a microcontroller into one of three low-power states and brings it back out. Software programs a two-bit depth selection and a three-bit stabilization-time code over a small register bus, then sets a standby-request bit. On the next cycle the sequencer enters the chosen depth and turns off a fixed set of clock and power domains: the core/peripheral clock, the flash, the PLL and the oscillator.

A wake-up event passes through a two-flop synchronizer. The light idle state returns to normal operation at once. The deep idle and halt states first pass through a resume state. That state keeps every domain on except the core clock and lasts for 2^(10+N) reference-clock cycles, where N is the stabilization code. Once the block is back in normal operation the request bit clears itself. A request made with the reserved depth code is refused, and a sticky error flag is set.

Top module: `standby_seq`

## Requirements
- R1: After reset all registers read 0x00, `state_o` is 0 (normal), all four domain enables are 1 and `err_o` is 0.
- R2: Register address 0 is the depth register. Only bits 1:0 are writable and bits 7:2 always read 0. A write changes only the bits set in `bus_wmask`: new = (old & ~mask) | (data & mask).
- R3: While the request bit (address 1, bit 0) is 0, the block stays in normal state whatever the depth register holds.
- R4: With the request bit set and depth code 01, the state becomes light idle (`state_o`=1) one cycle after the request bit is written. In light idle only the core clock is off.
- R5: With depth code 10 the state becomes deep idle (`state_o`=2). Core clock, flash and PLL are off and only the oscillator runs.
- R6: With depth code 11 the state becomes halt (`state_o`=3) and all four domain enables are 0.
- R7: From light idle, a wake-up input held high is seen in state 1 for two more clock edges. The state returns to normal (0) on the third edge, with no stabilization wait.
- R8: From deep idle or halt, a wake-up leads to the resume state (`state_o`=4), in which only the core clock is off. That state lasts exactly 2^(10+N) cycles, where N is the stabilization code, and the state then returns to normal.
- R9: A request made with depth code 00 leaves the state at normal. It sets `err_o` and bit 7 of address 1, and both stay set until reset. It also clears the request bit.
- R10: The request bit reads 0 once the block has returned to normal state.
- R11: Writes to the depth register are ignored while the block is in any state other than normal.
- R12: Address 2 holds the stabilization code in bits 2:0, which are writable under the bit mask. Bits 7:3 read 0, and address 3 reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on reference clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_wmask | input | 8 | Per-bit write enable |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| wake_async | input | 1 | Asynchronous wake-up event |
| state_o | output | 3 | 0 normal, 1 light idle, 2 deep idle, 3 halt, 4 resume |
| core_clk_en | output | 1 | Core/peripheral clock enable |
| flash_en | output | 1 | Flash enable |
| pll_en | output | 1 | PLL enable |
| osc_en | output | 1 | Oscillator enable |
| err_o | output | 1 | Sticky reserved-code request error |

## Verification
The bench measures the resume window cycle by cycle for two stabilization codes. An off-by-one counter would show up as a window of 1023 or 1025 cycles instead of 1024. It writes the depth register during every standby state, where a design missing the freeze would read back the new value. It checks the reserved 00 request: a faulty block would enter a low-power state or drop the sticky flag. It also checks that the light idle state exits on the third edge after wake-up, which a design that passed through the wait state or skipped the synchronizer would miss. Random masked writes probe the writable bits and the reserved bits.

// File: rtl/standby_pkg.sv
package standby_pkg;

    typedef enum logic [2:0] {
        ST_RUN    = 3'd0,
        ST_LIGHT  = 3'd1,
        ST_DEEP   = 3'd2,
        ST_HALT   = 3'd3,
        ST_RESUME = 3'd4
    } sb_state_e;

    typedef enum logic [1:0] {
        SEL_BAD   = 2'd0,
        SEL_LIGHT = 2'd1,
        SEL_DEEP  = 2'd2,
        SEL_HALT  = 2'd3
    } sb_sel_e;

    typedef struct packed {
        logic core;
        logic flash;
        logic pll;
        logic osc;
    } dom_en_t;

    localparam logic [1:0] ADR_DEPTH = 2'd0;
    localparam logic [1:0] ADR_CTRL  = 2'd1;
    localparam logic [1:0] ADR_STAB  = 2'd2;

    // Domains kept running in each state
    function automatic dom_en_t domains_for(sb_state_e s);
        dom_en_t d;
        case (s)
            ST_RUN:    d = '{core: 1'b1, flash: 1'b1, pll: 1'b1, osc: 1'b1};
            ST_LIGHT:  d = '{core: 1'b0, flash: 1'b1, pll: 1'b1, osc: 1'b1};
            ST_DEEP:   d = '{core: 1'b0, flash: 1'b0, pll: 1'b0, osc: 1'b1};
            ST_HALT:   d = '{core: 1'b0, flash: 1'b0, pll: 1'b0, osc: 1'b0};
            default:   d = '{core: 1'b0, flash: 1'b1, pll: 1'b1, osc: 1'b1};
        endcase
        return d;
    endfunction

    // Bit-masked merge of write data into a register
    function automatic logic [7:0] masked_merge(logic [7:0] old_v,
                                                logic [7:0] new_v,
                                                logic [7:0] mask);
        return (old_v & ~mask) | (new_v & mask);
    endfunction

    function automatic sb_state_e entry_state(sb_sel_e sel);
        case (sel)
            SEL_LIGHT: return ST_LIGHT;
            SEL_DEEP:  return ST_DEEP;
            SEL_HALT:  return ST_HALT;
            default:   return ST_RUN;
        endcase
    endfunction

endpackage

// File: rtl/sb_sync.sv
module sb_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= {chain_q[STAGES-2:0], d_i};
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/sb_regs.sv
module sb_regs
    import standby_pkg::*;
#(
    parameter int STAB_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_i,
    input  logic [1:0]        addr_i,
    input  logic [7:0]        wdata_i,
    input  logic [7:0]        wmask_i,
    input  logic              standby_i,
    input  logic              stp_clr_i,
    input  logic              err_set_i,
    output logic [1:0]        sel_o,
    output logic              stp_o,
    output logic [STAB_W-1:0] stab_o,
    output logic              err_o,
    output logic [7:0]        rdata_o
);
    localparam logic [7:0] DEPTH_WR = 8'h03;
    localparam logic [7:0] CTRL_WR  = 8'h01;
    localparam logic [7:0] STAB_WR  = 8'((1 << STAB_W) - 1);

    logic [7:0] depth_q, ctrl_q, stab_q;
    logic       err_q;
    logic       wr_depth, wr_ctrl, wr_stab;

    assign wr_depth = wr_i && (addr_i == ADR_DEPTH) && !standby_i;
    assign wr_ctrl  = wr_i && (addr_i == ADR_CTRL);
    assign wr_stab  = wr_i && (addr_i == ADR_STAB);

    always_ff @(posedge clk) begin
        if (rst) begin
            depth_q <= '0;
            ctrl_q  <= '0;
            stab_q  <= '0;
            err_q   <= 1'b0;
        end else begin
            if (wr_depth)
                depth_q <= masked_merge(depth_q, wdata_i, wmask_i) & DEPTH_WR;
            if (stp_clr_i)
                ctrl_q <= '0;
            else if (wr_ctrl)
                ctrl_q <= masked_merge(ctrl_q, wdata_i, wmask_i) & CTRL_WR;
            if (wr_stab)
                stab_q <= masked_merge(stab_q, wdata_i, wmask_i) & STAB_WR;
            if (err_set_i)
                err_q <= 1'b1;
        end
    end

    always_comb begin
        case (addr_i)
            ADR_DEPTH: rdata_o = depth_q;
            ADR_CTRL:  rdata_o = ctrl_q | {err_q, 7'b0};
            ADR_STAB:  rdata_o = stab_q;
            default:   rdata_o = '0;
        endcase
    end

    assign sel_o  = depth_q[1:0];
    assign stp_o  = ctrl_q[0];
    assign stab_o = stab_q[STAB_W-1:0];
    assign err_o  = err_q;

    assert_depth_frozen_R11: assert property (@(posedge clk) disable iff (rst)
        standby_i |=> $stable(depth_q));
    assert_err_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        err_q |=> err_q);
    assert_depth_upper_zero_R2: assert property (@(posedge clk) disable iff (rst)
        (addr_i == ADR_DEPTH) |-> (rdata_o[7:2] == 6'b0));
    assert_stp_cleared_R10: assert property (@(posedge clk) disable iff (rst)
        stp_clr_i |=> !ctrl_q[0]);
endmodule

// File: rtl/sb_fsm.sv
module sb_fsm
    import standby_pkg::*;
#(
    parameter int STAB_W   = 3,
    parameter int BASE_EXP = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              stp_i,
    input  logic [1:0]        sel_i,
    input  logic [STAB_W-1:0] stab_i,
    input  logic              wake_i,
    output sb_state_e         state_o,
    output logic              standby_o,
    output logic              stp_clr_o,
    output logic              err_set_o
);
    localparam int CNT_W = BASE_EXP + (1 << STAB_W) - 1;

    sb_state_e        state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [CNT_W-1:0] load_val;
    sb_sel_e          sel;

    assign sel      = sb_sel_e'(sel_i);
    assign load_val = CNT_W'((64'd1 << (BASE_EXP + int'(stab_i))) - 64'd1);

    always_comb begin
        state_d   = state_q;
        cnt_d     = cnt_q;
        stp_clr_o = 1'b0;
        err_set_o = 1'b0;
        case (state_q)
            ST_RUN: begin
                if (stp_i) begin
                    if (sel == SEL_BAD) begin
                        err_set_o = 1'b1;
                        stp_clr_o = 1'b1;
                    end else begin
                        state_d = entry_state(sel);
                    end
                end
            end
            ST_LIGHT: begin
                if (wake_i) begin
                    state_d   = ST_RUN;
                    stp_clr_o = 1'b1;
                end
            end
            ST_DEEP, ST_HALT: begin
                if (wake_i) begin
                    state_d = ST_RESUME;
                    cnt_d   = load_val;
                end
            end
            default: begin
                if (cnt_q == '0) begin
                    state_d   = ST_RUN;
                    stp_clr_o = 1'b1;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_RUN;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    assign state_o   = state_q;
    assign standby_o = (state_q != ST_RUN);

    assert_no_entry_without_req_R3: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_RUN && !stp_i) |=> (state_q == ST_RUN));
    assert_light_entry_R4: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_RUN && stp_i && sel_i == 2'd1) |=> (state_q == ST_LIGHT));
    assert_light_fast_exit_R7: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_LIGHT && wake_i) |=> (state_q == ST_RUN));
    assert_resume_countdown_R8: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_RESUME && cnt_q != '0) |=>
            (state_q == ST_RESUME && cnt_q == $past(cnt_q) - 1'b1));
    assert_bad_code_stays_R9: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_RUN && stp_i && sel_i == 2'd0) |=> (state_q == ST_RUN));
endmodule

// File: rtl/standby_seq.sv
module standby_seq
    import standby_pkg::*;
#(
    parameter int STAB_W      = 3,
    parameter int BASE_EXP    = 10,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       bus_wr,
    input  logic [1:0] bus_addr,
    input  logic [7:0] bus_wdata,
    input  logic [7:0] bus_wmask,
    output logic [7:0] bus_rdata,
    input  logic       wake_async,
    output logic [2:0] state_o,
    output logic       core_clk_en,
    output logic       flash_en,
    output logic       pll_en,
    output logic       osc_en,
    output logic       err_o
);
    logic              wake_s;
    logic [1:0]        sel;
    logic              stp;
    logic [STAB_W-1:0] stab;
    logic              standby, stp_clr, err_set;
    sb_state_e         state;
    dom_en_t           dom;

    sb_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (wake_async),
        .q_o (wake_s)
    );

    sb_regs #(.STAB_W(STAB_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_i      (bus_wr),
        .addr_i    (bus_addr),
        .wdata_i   (bus_wdata),
        .wmask_i   (bus_wmask),
        .standby_i (standby),
        .stp_clr_i (stp_clr),
        .err_set_i (err_set),
        .sel_o     (sel),
        .stp_o     (stp),
        .stab_o    (stab),
        .err_o     (err_o),
        .rdata_o   (bus_rdata)
    );

    sb_fsm #(.STAB_W(STAB_W), .BASE_EXP(BASE_EXP)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .stp_i     (stp),
        .sel_i     (sel),
        .stab_i    (stab),
        .wake_i    (wake_s),
        .state_o   (state),
        .standby_o (standby),
        .stp_clr_o (stp_clr),
        .err_set_o (err_set)
    );

    assign dom         = domains_for(state);
    assign state_o     = state;
    assign core_clk_en = dom.core;
    assign flash_en    = dom.flash;
    assign pll_en      = dom.pll;
    assign osc_en      = dom.osc;

    assert_halt_keeps_request_R6: assert property (@(posedge clk) disable iff (rst)
        (state == ST_HALT) |-> stp);
endmodule

// File: tb/standby_seq_bench.sv
module standby_seq_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_wr = 1'b0;
    logic [1:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_wmask = '0;
    logic [7:0] bus_rdata;
    logic       wake_async = 1'b0;
    logic [2:0] state_o;
    logic       core_clk_en, flash_en, pll_en, osc_en, err_o;

    int tests = 0;
    int fails = 0;
    bit done = 0;

    always #5 clk = ~clk;

    standby_seq u_standby_seq (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_wmask(bus_wmask), .bus_rdata(bus_rdata),
        .wake_async(wake_async), .state_o(state_o), .core_clk_en(core_clk_en),
        .flash_en(flash_en), .pll_en(pll_en), .osc_en(osc_en), .err_o(err_o)
    );

    function automatic logic [3:0] exp_dom(int st);
        case (st)
            0: return 4'b1111;
            1: return 4'b0111;
            2: return 4'b0001;
            3: return 4'b0000;
            default: return 4'b0111;
        endcase
    endfunction

    function automatic logic [7:0] merge(logic [7:0] o, logic [7:0] d,
                                         logic [7:0] m, logic [7:0] wr);
        return ((o & ~m) | (d & m)) & wr;
    endfunction

    task automatic check(string req, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic tick(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(logic [1:0] a, logic [7:0] d, logic [7:0] m);
        bus_addr = a; bus_wdata = d; bus_wmask = m; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(logic [1:0] a, output logic [7:0] v);
        bus_addr = a;
        #1 v = bus_rdata;
    endtask

    function automatic logic [3:0] doms();
        return {core_clk_en, flash_en, pll_en, osc_en};
    endfunction

    logic [7:0] m_depth = 0, m_stab = 0, rv;

    // Enter a standby depth, check it, test frozen depth writes, wake, measure.
    task automatic cycle_mode(int code, int n);
        int cnt;
        wr(2'd2, 8'(n), 8'hFF); m_stab = 8'(n);
        wr(2'd0, 8'(code), 8'hFF); m_depth = 8'(code);
        wr(2'd1, 8'h01, 8'h01);
        tick(1);
        check($sformatf("R4/R5/R6 state code %0d", code), state_o, code);
        check($sformatf("R4/R5/R6 domains code %0d", code), doms(), exp_dom(code));
        wr(2'd0, ~8'(code), 8'hFF);
        rd(2'd0, rv);
        check("R11 depth write ignored", rv, code);
        wake_async = 1'b1;
        tick(2);
        check("R7 synchronizer delay", state_o, code);
        tick(1);
        if (code == 1) begin
            check("R7 light exit no wait", state_o, 0);
        end else begin
            check("R8 resume state", state_o, 4);
            check("R8 resume domains", doms(), exp_dom(4));
            cnt = 0;
            while (state_o == 3'd4 && cnt < 200000) begin
                cnt++;
                tick(1);
            end
            check($sformatf("R8 wait length N=%0d", n), cnt, 1 << (10 + n));
            check("R8 back to normal", state_o, 0);
        end
        rd(2'd1, rv);
        check("R10 request cleared", rv[0], 0);
        wake_async = 1'b0;
        tick(4);
        check("R1 normal domains", doms(), exp_dom(0));
    endtask

    initial begin
        logic [7:0] d, m;
        void'($urandom(32'h5EED));
        tick(3);
        rst = 1'b0;
        tick(1);
        // R1 reset state
        check("R1 state", state_o, 0);
        check("R1 domains", doms(), 4'hF);
        check("R1 err", err_o, 0);
        for (int a = 0; a < 3; a++) begin
            rd(2'(a), rv);
            check("R1 reg reset", rv, 0);
        end
        // R2 / R12 random masked writes
        for (int i = 0; i < 20; i++) begin
            d = 8'($urandom); m = 8'($urandom);
            wr(2'd0, d, m); m_depth = merge(m_depth, d, m, 8'h03);
            rd(2'd0, rv);
            check("R2 depth masked write", rv, m_depth);
            d = 8'($urandom); m = 8'($urandom);
            wr(2'd2, d, m); m_stab = merge(m_stab, d, m, 8'h07);
            rd(2'd2, rv);
            check("R12 stab masked write", rv, m_stab);
        end
        wr(2'd3, 8'hFF, 8'hFF);
        rd(2'd3, rv);
        check("R12 unused address", rv, 0);
        // R3 no entry without request bit
        wr(2'd0, 8'h03, 8'hFF);
        tick(5);
        check("R3 stays normal", state_o, 0);
        check("R3 domains", doms(), 4'hF);
        // R9 reserved code
        wr(2'd0, 8'h00, 8'hFF);
        wr(2'd1, 8'h01, 8'h01);
        tick(2);
        check("R9 stays normal", state_o, 0);
        check("R9 err flag", err_o, 1);
        rd(2'd1, rv);
        check("R9 ctrl read", rv, 8'h80);
        // Directed depths
        cycle_mode(1, 0);
        cycle_mode(2, 0);
        cycle_mode(3, 1);
        // Random depths
        for (int i = 0; i < 8; i++)
            cycle_mode(1 + int'($urandom_range(0, 2)), int'($urandom_range(0, 1)));
        check("R9 err still set", err_o, 1);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #1900000;
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule